// File: doc/BRIEF.md
# Multi-Latency Issue Scoreboard

This block is the issue gate of an in-order pipeline whose execution units finish after different numbers of cycles. Each cycle it looks at the instruction held in decode (its unit class, destination register and two source registers) and decides whether that instruction may leave decode at the next clock edge. If it may not, the instruction stays held.

The gate checks four things. A source must not wait on a result that cannot yet be forwarded. A destination must not have an older write that would land at or after the new one, which would be a write-after-write hazard caused by out-of-order completion. A busy unpipelined unit takes no new operation. The single writeback port must still be free in the cycle where the new result would land. The units are modelled only as latency counters, and the arithmetic lies outside the block. Every register's pending status is exported so that neighbouring logic can see which results are still in flight.

Unit class codes on `unit_i`: 0 integer ALU (latency 0, accepts every cycle), 1 load (latency 1, every cycle), 2 FP adder (latency 3, every cycle), 3 multiplier (latency 6, every cycle), 4 divider (latency 24, accepts once every 25 cycles). All latencies and intervals are parameters.

Top module: `fu_issue_scoreboard`

## Requirements
- R1: After reset no register is pending, no writeback slot is reserved and every unit is idle, so a valid instruction of any class issues at once.
- R2: `issue_o` is high only while `valid_i` is high. A cycle with `valid_i` low changes no tracking state: it reserves no unit, no register and no slot. `stall_o` is high exactly when `valid_i` is high and `issue_o` is low.
- R3: An instruction issued in cycle t by a unit of latency L makes a consumer of its destination wait until cycle t+L+1. For this reason an ALU result (L=0) can be used by the very next instruction.
- R4: An instruction is held while its destination has an older pending write that would complete in the same cycle as the new write or later. A write to the same register that completes after the older one issues at once.
- R5: An instruction issued in cycle t with latency L uses the single writeback port in cycle t+L+1. If another issued instruction already holds that cycle, the new one is held.
- R6: The divider (class 4) accepts a new divide no sooner than 25 cycles after the previous one issued. A second divide therefore waits 24 cycles when it is presented right after the first.
- R7: Units with an initiation interval of 1 (classes 0 to 3) accept independent operations in consecutive cycles without stalling.
- R8: `pending_o[r]` is high from the cycle after an issue that writes r until the result becomes forwardable, which is L cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decode holds an instruction |
| unit_i | input | 3 | Unit class code of the held instruction |
| dst_i | input | REG_W | Destination register |
| src1_i | input | REG_W | First source register |
| src2_i | input | REG_W | Second source register |
| issue_o | output | 1 | Instruction leaves decode at the next edge |
| stall_o | output | 1 | Instruction is held in decode |
| pending_o | output | NUM_REGS | Per-register write still in flight |

## Verification
The bench builds the block with its default values: 32 registers, latencies 0/1/3/6/24 and a divider interval of 25. These values create several specific cases. A multiply followed three cycles later by an add lands both results in the same writeback cycle. An add that writes the same register as an earlier multiply must wait three cycles on the write-after-write check. A second divide waits 24 cycles, and a consumer of its result waits up to 23 cycles. The 26-slot reservation window and the 5-bit counters are also driven to their upper values.

// File: rtl/fu_sb_pkg.sv
package fu_sb_pkg;
  typedef enum logic [2:0] {
    UC_ALU  = 3'd0,
    UC_LOAD = 3'd1,
    UC_FADD = 3'd2,
    UC_MUL  = 3'd3,
    UC_DIV  = 3'd4
  } unit_e;

  localparam int unsigned NUM_UNITS = 5;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sb_unit_gate.sv
// Structural-hazard gate for one unit class; II==1 needs no state.
module sb_unit_gate #(
  parameter int unsigned II = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic busy_o
);
  generate
    if (II <= 1) begin : g_pipe
      logic unused_take;
      assign unused_take = take_i;
      assign busy_o      = 1'b0;
    end else begin : g_iter
      localparam int unsigned W = $clog2(II);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (take_i)       cnt_q <= W'(II - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end

      assign busy_o = (cnt_q != '0);

      // R6
      unit_idle_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/sb_reg_track.sv
// Per-register cycles-until-forwardable counters.
module sb_reg_track #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned CNT_W    = 5,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               set_i,
  input  logic [REG_W-1:0]                   dst_i,
  input  logic [CNT_W-1:0]                   lat_i,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     cnt_o
);
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q[r] <= '0;
      else if (set_i && dst_i == REG_W'(r))     cnt_q[r] <= lat_i;
      else if (cnt_q[r] != '0)                  cnt_q[r] <= cnt_q[r] - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R4
  no_early_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> (cnt_q[dst_i] <= lat_i));
endmodule

// File: rtl/sb_wb_slots.sv
// Writeback reservation vector: bit k = port used k cycles from now.
module sb_wb_slots #(
  parameter int unsigned SLOTS    = 26,
  localparam int unsigned SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              claim_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOTS-1:0]  res_o
);
  logic [SLOTS-1:0] res_q;
  logic [SLOTS-1:0] res_merged;

  always_comb begin
    res_merged = res_q;
    if (claim_i) res_merged[slot_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_merged >> 1;
  end

  assign res_o = res_q;

  // R5
  slot_free_on_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |-> !res_q[slot_i]);
endmodule

// File: rtl/fu_issue_scoreboard.sv
module fu_issue_scoreboard
  import fu_sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LAT_ALU  = 0,
  parameter int unsigned LAT_LOAD = 1,
  parameter int unsigned LAT_FADD = 3,
  parameter int unsigned LAT_MUL  = 6,
  parameter int unsigned LAT_DIV  = 24,
  parameter int unsigned II_ALU   = 1,
  parameter int unsigned II_LOAD  = 1,
  parameter int unsigned II_FADD  = 1,
  parameter int unsigned II_MUL   = 1,
  parameter int unsigned II_DIV   = 25,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           unit_i,
  input  logic [REG_W-1:0]     dst_i,
  input  logic [REG_W-1:0]     src1_i,
  input  logic [REG_W-1:0]     src2_i,
  output logic                 issue_o,
  output logic                 stall_o,
  output logic [NUM_REGS-1:0]  pending_o
);
  localparam int unsigned MAX_LAT =
    umax(umax(umax(LAT_ALU, LAT_LOAD), umax(LAT_FADD, LAT_MUL)), LAT_DIV);
  localparam int unsigned CNT_W  = $clog2(MAX_LAT + 2);
  localparam int unsigned SLOTS  = MAX_LAT + 2;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  function automatic int unsigned ii_of(input int unsigned k);
    case (k)
      0:       return II_ALU;
      1:       return II_LOAD;
      2:       return II_FADD;
      3:       return II_MUL;
      default: return II_DIV;
    endcase
  endfunction

  logic [CNT_W-1:0]               lat;
  logic [SLOT_W-1:0]              slot;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
  logic [SLOTS-1:0]               res;
  logic [NUM_UNITS-1:0]           unit_busy;
  logic                           raw_hit, waw_hit, port_hit, struct_hit;

  always_comb begin
    case (unit_e'(unit_i))
      UC_LOAD: lat = CNT_W'(LAT_LOAD);
      UC_FADD: lat = CNT_W'(LAT_FADD);
      UC_MUL:  lat = CNT_W'(LAT_MUL);
      UC_DIV:  lat = CNT_W'(LAT_DIV);
      default: lat = CNT_W'(LAT_ALU);
    endcase
  end

  assign slot = SLOT_W'(lat) + 1'b1;

  always_comb begin
    struct_hit = 1'b0;
    for (int k = 0; k < NUM_UNITS; k++)
      if (unit_i == 3'(k)) struct_hit = unit_busy[k];
  end

  assign raw_hit  = (cnt[src1_i] != '0) || (cnt[src2_i] != '0);
  assign waw_hit  = (cnt[dst_i] > lat);
  assign port_hit = res[slot];

  assign issue_o = valid_i && !(raw_hit || waw_hit || port_hit || struct_hit);
  assign stall_o = valid_i && !issue_o;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    sb_unit_gate #(.II(ii_of(k))) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (issue_o && unit_i == 3'(k)),
      .busy_o (unit_busy[k])
    );
  end

  sb_reg_track #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (issue_o),
    .dst_i  (dst_i),
    .lat_i  (lat),
    .cnt_o  (cnt)
  );

  sb_wb_slots #(.SLOTS(SLOTS)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .claim_i (issue_o),
    .slot_i  (slot),
    .res_o   (res)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
    assign pending_o[r] = (cnt[r] != '0);
  end

  // R3
  alu_result_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && unit_i == 3'(UC_ALU) && LAT_ALU == 0) |=> !pending_o[$past(dst_i)]);

  // R2
  idle_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!issue_o && !stall_o));
endmodule

// File: tb/tb_fu_issue_scoreboard.sv
module tb_fu_issue_scoreboard;
  localparam int unsigned NREG = 32;
  localparam int unsigned RW   = $clog2(NREG);
  localparam int NROWS = 19;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [2:0]      unit = '0;
  logic [RW-1:0]   dst = '0, s1 = '0, s2 = '0;
  logic            issue, stall;
  logic [NREG-1:0] pending;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fu_issue_scoreboard #(.NUM_REGS(NREG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .unit_i(unit),
    .dst_i(dst), .src1_i(s1), .src2_i(s2),
    .issue_o(issue), .stall_o(stall), .pending_o(pending)
  );

  // {req, unit, dst, src1, src2, idle cycles before, expected stall cycles}
  // unit codes: 0 ALU, 1 load, 2 FP add, 3 mul, 4 div
  localparam logic [37:0] VEC [NROWS] = '{
    {4'd3, 3'd0, 5'd1,  5'd2,  5'd3, 8'd0,  8'd0},  // R3 ALU
    {4'd3, 3'd0, 5'd4,  5'd1,  5'd1, 8'd0,  8'd0},  // R3 ALU->ALU forward
    {4'd7, 3'd1, 5'd6,  5'd4,  5'd4, 8'd0,  8'd0},  // R7 load
    {4'd3, 3'd0, 5'd7,  5'd6,  5'd0, 8'd0,  8'd1},  // R3 load-use
    {4'd7, 3'd3, 5'd5,  5'd1,  5'd2, 8'd0,  8'd0},  // R7 mul
    {4'd4, 3'd2, 5'd5,  5'd1,  5'd2, 8'd0,  8'd3},  // R4 add after mul same dst
    {4'd3, 3'd2, 5'd8,  5'd5,  5'd1, 8'd0,  8'd3},  // R3 dependent add
    {4'd7, 3'd3, 5'd9,  5'd2,  5'd3, 8'd10, 8'd0},  // R7
    {4'd7, 3'd0, 5'd10, 5'd2,  5'd3, 8'd0,  8'd0},  // R7
    {4'd7, 3'd0, 5'd11, 5'd2,  5'd3, 8'd0,  8'd0},  // R7
    {4'd5, 3'd2, 5'd12, 5'd2,  5'd3, 8'd0,  8'd1},  // R5 port collides with mul
    {4'd6, 3'd4, 5'd13, 5'd2,  5'd3, 8'd10, 8'd0},  // R6 first divide
    {4'd6, 3'd4, 5'd14, 5'd2,  5'd3, 8'd0,  8'd24}, // R6 back-to-back divide
    {4'd3, 3'd0, 5'd15, 5'd13, 5'd0, 8'd0,  8'd0},  // R3 div result ready
    {4'd3, 3'd0, 5'd16, 5'd14, 5'd0, 8'd0,  8'd23}, // R3 waits on second divide
    {4'd7, 3'd2, 5'd17, 5'd1,  5'd2, 8'd0,  8'd0},  // R7 pipelined add
    {4'd7, 3'd2, 5'd18, 5'd1,  5'd2, 8'd0,  8'd0},  // R7 pipelined add
    {4'd7, 3'd2, 5'd19, 5'd1,  5'd2, 8'd0,  8'd0},  // R7
    {4'd4, 3'd3, 5'd19, 5'd1,  5'd2, 8'd0,  8'd0}   // R4 later-completing WAW ok
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Presents at a negedge, returns at the negedge after the issuing edge.
  task automatic run(input logic [2:0] u, input logic [4:0] d, input logic [4:0] a,
                     input logic [4:0] b, output int stalls);
    unit = u; dst = RW'(d); s1 = RW'(a); s2 = RW'(b); valid = 1'b1;
    stalls = 0;
    #1;
    while (!issue && stalls < 200) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 pending after reset", int'(pending), 0);
    chk("R2 issue with valid low", int'(issue), 0);
    chk("R2 stall with valid low", int'(stall), 0);
    unit = 3'd4; dst = 5'd1; s1 = 5'd2; s2 = 5'd3; valid = 1'b1; #1;
    chk("R1 divide issues at once", int'(issue), 1);
    valid = 1'b0;
    // divide offered with valid low for several edges: must reserve nothing (R2)
    repeat (4) @(negedge clk);
    #1;
    chk("R2 pending after invalid cycles", int'(pending), 0);

    for (int i = 0; i < NROWS; i++) begin
      logic [37:0] row;
      row = VEC[i];
      repeat (int'(row[15:8])) @(negedge clk);
      run(row[33:31], row[30:26], row[25:21], row[20:16], st);
      chk($sformatf("R%0d row %0d stall cycles", int'(row[37:34]), i), st, int'(row[7:0]));
    end

    repeat (60) @(negedge clk);
    // R8 pending window for a multiply to r20
    run(3'd3, 5'd20, 5'd1, 5'd2, st);
    #1;
    chk("R8 pending r20 first cycle", int'(pending[20]), 1);
    repeat (5) @(negedge clk);
    #1;
    chk("R8 pending r20 sixth cycle", int'(pending[20]), 1);
    @(negedge clk); #1;
    chk("R8 pending r20 cleared", int'(pending[20]), 0);

    // R2: divide offered with valid low must not occupy the divider
    unit = 3'd4; valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 stall low while idle", int'(stall), 0);
    run(3'd4, 5'd21, 5'd1, 5'd2, st);
    chk("R2 divide after invalid offers", st, 0);
    #1;
    chk("R8 pending r21 after divide", int'(pending[21]), 1);
    // stall_o tracks a held instruction
    unit = 3'd4; dst = 5'd22; s1 = 5'd1; s2 = 5'd2; valid = 1'b1; #1;
    chk("R6 second divide held", int'(issue), 0);
    chk("R2 stall high when held", int'(stall), 1);
    valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule